// File: doc/BRIEF.md
# Link Power Status Watchdog

This block sits on the PHY side of a PHY/link interface and watches a status input that reports whether the link layer is powered. It runs on a free-running local reference clock. While the status input stays low, it acts in two stages. At the first timeout it requests an interface reset and parks the eight data lines and the two control lines in a safe state. At the second, longer timeout it also removes the enable from the interface clock that the PHY supplies to the link.

The bus drivers are parked in one of two ways, chosen by a static coupling-mode input. With the input high, the link is wired directly: parked lines are driven low and the stopped clock pin is held low. With the input low, the link sits behind an isolation barrier: parked lines and the stopped clock pin are released to high impedance. When the status input returns high, the clock comes back first. One reference cycle later the interface reset is released, and the buses return to the direction control that the PHY core requests.

Top module: `lps_watchdog`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block in stage code 2, with `link_rst`=1 and `link_clk_en`=0. It stays in that stage after reset is released until the status input has been sampled high.
- R2: Once the synchronized status input has been low for T1_CYC consecutive reference cycles, the stage code becomes 1, `link_rst`=1 and `link_clk_en`=1. Counted in reference edges after the input falls, the output changes after edge T1_CYC+2 and stays code 0 through edge T1_CYC+1.
- R3: Once the synchronized input has been low for T2_CYC consecutive cycles (output change after edge T2_CYC+2), the stage code becomes 2, `link_rst`=1 and `link_clk_en`=0.
- R4: The low-time counter saturates at T2_CYC, so any longer low period leaves the block in stage code 2 without wrapping.
- R5: The status input passes through a two-flop synchronizer. A single high sample clears the low-time count, and the next low period is timed from zero.
- R6: After the input rises, `link_clk_en` returns to 1 after the third reference edge while `link_rst` stays 1 and the stage code reads 1. After the fourth edge the stage code is 0 and `link_rst`=0.
- R7: In direct mode (`direct_mode`=1), while `link_rst`=1, `link_data_oe`=1, `link_ctl_oe`=1, `link_data_o`=0 and `link_ctl_o`=0.
- R8: In isolated mode (`direct_mode`=0), while `link_rst`=1, `link_data_oe`=0 and `link_ctl_oe`=0, and the drive values are 0.
- R9: `link_clk_oe` is 1 at all times in direct mode, so a stopped clock pin is held low. In isolated mode it equals `link_clk_en`.
- R10: While `link_rst`=0, the four link bus outputs equal the corresponding core-side inputs.
- R11: The stage code is 0 for normal, 1 for interface reset (including the one-cycle recovery step) and 2 for clock stopped. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lps_in | input | 1 | Asynchronous link power status, high = link powered |
| direct_mode | input | 1 | Coupling mode, 1 = direct, 0 = isolated |
| core_data_o | input | 8 | Data byte value requested by the PHY core |
| core_data_oe | input | 1 | Data byte output enable requested by the PHY core |
| core_ctl_o | input | 2 | Control bits value requested by the PHY core |
| core_ctl_oe | input | 1 | Control bits output enable requested by the PHY core |
| link_data_o | output | 8 | Data byte drive value toward the link |
| link_data_oe | output | 1 | Data byte output enable toward the link |
| link_ctl_o | output | 2 | Control bits drive value toward the link |
| link_ctl_oe | output | 1 | Control bits output enable toward the link |
| link_rst | output | 1 | PHY/link interface reset request |
| link_clk_en | output | 1 | Enable for the clock supplied to the link |
| link_clk_oe | output | 1 | Output enable of the link clock pin |
| stage_code | output | 2 | Current stage: 0 normal, 1 interface reset, 2 clock stopped |

## Verification
The hardest condition to reach from the ports is a low period that ends exactly one edge before or one edge after a threshold. The synchronizer adds latency, and a stray high sample silently restarts the count. The stimulus drops the input on a falling clock edge, waits a counted number of rising edges (T1_CYC+1 against T1_CYC+2, T2_CYC+1 against T2_CYC+2) and samples on the next falling edge. A one-cycle high pulse inserted just before the first threshold shows that the count restarts from zero. Both recovery paths are stepped edge by edge to catch the single cycle in which the clock runs while the reset is still held.

// File: rtl/lps_wd_pkg.sv
package lps_wd_pkg;

    localparam int DATA_W = 8;
    localparam int CTL_W  = 2;

    typedef enum logic [1:0] {
        ST_NORMAL  = 2'd0,
        ST_IFRST   = 2'd1,
        ST_CLKOFF  = 2'd2,
        ST_RECOVER = 2'd3
    } lps_stage_e;

    typedef struct packed {
        logic [DATA_W-1:0] data_o;
        logic              data_oe;
        logic [CTL_W-1:0]  ctl_o;
        logic              ctl_oe;
    } bus_ctl_t;

    // Externally visible stage code; recovery reports as interface reset.
    function automatic logic [1:0] stage_to_code(input lps_stage_e st);
        case (st)
            ST_NORMAL:  return 2'd0;
            ST_IFRST:   return 2'd1;
            ST_CLKOFF:  return 2'd2;
            default:    return 2'd1;
        endcase
    endfunction

    // Parked bus: driven low when direct, released when isolated.
    function automatic bus_ctl_t parked_bus(input logic direct);
        bus_ctl_t b;
        b.data_o  = '0;
        b.ctl_o   = '0;
        b.data_oe = direct;
        b.ctl_oe  = direct;
        return b;
    endfunction

endpackage

// File: rtl/lps_sync.sv
module lps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[LAST];
endmodule

// File: rtl/lps_timer.sv
module lps_timer
    import lps_wd_pkg::*;
#(
    parameter int T1_CYC = 59,
    parameter int T2_CYC = 123
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lps_s,
    output lps_stage_e stage
);
    localparam int CNT_W = $clog2(T2_CYC + 1);
    localparam logic [CNT_W-1:0] T1_C = CNT_W'(T1_CYC);
    localparam logic [CNT_W-1:0] T2_C = CNT_W'(T2_CYC);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_n;
    lps_stage_e       low_stage;
    lps_stage_e       high_stage;

    // Saturating increment while the status stays low.
    always_comb begin
        if (cnt >= T2_C) cnt_n = T2_C;
        else             cnt_n = cnt + 1'b1;
    end

    always_comb begin
        if (cnt_n >= T2_C)      low_stage = ST_CLKOFF;
        else if (cnt_n >= T1_C) low_stage = ST_IFRST;
        else                    low_stage = ST_NORMAL;
    end

    // Leaving any reset stage passes through one recovery cycle.
    always_comb begin
        if (stage == ST_NORMAL || stage == ST_RECOVER) high_stage = ST_NORMAL;
        else                                             high_stage = ST_RECOVER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= T2_C;
            stage <= ST_CLKOFF;
        end else if (lps_s) begin
            cnt   <= '0;
            stage <= high_stage;
        end else begin
            cnt   <= cnt_n;
            stage <= low_stage;
        end
    end

    assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= T2_C);

    assert_clkoff_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!lps_s && stage == ST_CLKOFF) |=> stage == ST_CLKOFF);

    assert_high_clears_R5: assert property (@(posedge clk) disable iff (rst)
        lps_s |=> (stage == ST_NORMAL || stage == ST_RECOVER));

    assert_recover_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        stage == ST_RECOVER |=> stage == ST_NORMAL);
endmodule

// File: rtl/lps_bus_park.sv
module lps_bus_park
    import lps_wd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     direct_mode,
    input  logic     park,
    input  logic     clk_en,
    input  bus_ctl_t core_bus,
    output bus_ctl_t link_bus,
    output logic     clk_oe
);
    always_comb begin
        if (park) link_bus = parked_bus(direct_mode);
        else      link_bus = core_bus;
    end

    // Direct coupling keeps the clock pin driven (low when stopped).
    assign clk_oe = direct_mode | clk_en;

    assert_direct_park_R7: assert property (@(posedge clk) disable iff (rst)
        (park && direct_mode) |-> (link_bus.data_oe && link_bus.ctl_oe &&
                                   link_bus.data_o == '0 && link_bus.ctl_o == '0));

    assert_iso_park_R8: assert property (@(posedge clk) disable iff (rst)
        (park && !direct_mode) |-> (!link_bus.data_oe && !link_bus.ctl_oe));

    assert_iso_clk_pin_R9: assert property (@(posedge clk) disable iff (rst)
        (!direct_mode && !clk_en) |-> !clk_oe);
endmodule

// File: rtl/lps_watchdog.sv
module lps_watchdog
    import lps_wd_pkg::*;
#(
    parameter int T1_CYC      = 59,
    parameter int T2_CYC      = 123,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lps_in,
    input  logic              direct_mode,
    input  logic [DATA_W-1:0] core_data_o,
    input  logic              core_data_oe,
    input  logic [CTL_W-1:0]  core_ctl_o,
    input  logic              core_ctl_oe,
    output logic [DATA_W-1:0] link_data_o,
    output logic              link_data_oe,
    output logic [CTL_W-1:0]  link_ctl_o,
    output logic              link_ctl_oe,
    output logic              link_rst,
    output logic              link_clk_en,
    output logic              link_clk_oe,
    output logic [1:0]        stage_code
);
    logic       lps_s;
    lps_stage_e stage;
    bus_ctl_t   core_bus;
    bus_ctl_t   link_bus;

    lps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (lps_in),
        .q   (lps_s)
    );

    lps_timer #(.T1_CYC(T1_CYC), .T2_CYC(T2_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .lps_s (lps_s),
        .stage (stage)
    );

    assign link_rst    = (stage != ST_NORMAL);
    assign link_clk_en = (stage != ST_CLKOFF);
    assign stage_code  = stage_to_code(stage);

    always_comb begin
        core_bus.data_o  = core_data_o;
        core_bus.data_oe = core_data_oe;
        core_bus.ctl_o   = core_ctl_o;
        core_bus.ctl_oe  = core_ctl_oe;
    end

    lps_bus_park u_park (
        .clk         (clk),
        .rst         (rst),
        .direct_mode (direct_mode),
        .park        (link_rst),
        .clk_en      (link_clk_en),
        .core_bus    (core_bus),
        .link_bus    (link_bus),
        .clk_oe      (link_clk_oe)
    );

    assign link_data_o  = link_bus.data_o;
    assign link_data_oe = link_bus.data_oe;
    assign link_ctl_o   = link_bus.ctl_o;
    assign link_ctl_oe  = link_bus.ctl_oe;

    assert_code_range_R11: assert property (@(posedge clk) disable iff (rst)
        stage_code != 2'd3);

    assert_clk_before_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(link_clk_en) |-> link_rst);

    assert_clkoff_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
        !link_clk_en |-> link_rst);

    assert_pass_through_R10: assert property (@(posedge clk) disable iff (rst)
        !link_rst |-> (link_data_o == core_data_o && link_data_oe == core_data_oe &&
                       link_ctl_o == core_ctl_o && link_ctl_oe == core_ctl_oe));
endmodule

// File: tb/test_lps_watchdog.sv
module test_lps_watchdog;
    localparam int T1 = 59;
    localparam int T2 = 123;
    localparam int NV = 10;

    typedef struct packed {
        logic       dm;
        int         n;
        logic [1:0] st;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, T1 + 1, 2'd0},
        '{1'b1, T1 + 2, 2'd1},
        '{1'b1, T2 + 1, 2'd1},
        '{1'b1, T2 + 2, 2'd2},
        '{1'b0, T1 + 1, 2'd0},
        '{1'b0, T1 + 2, 2'd1},
        '{1'b0, T2 + 1, 2'd1},
        '{1'b0, T2 + 2, 2'd2},
        '{1'b1, 2000,   2'd2},
        '{1'b0, 5,      2'd0}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       lps_in;
    logic       direct_mode;
    logic [7:0] core_data_o;
    logic       core_data_oe;
    logic [1:0] core_ctl_o;
    logic       core_ctl_oe;
    logic [7:0] link_data_o;
    logic       link_data_oe;
    logic [1:0] link_ctl_o;
    logic       link_ctl_oe;
    logic       link_rst;
    logic       link_clk_en;
    logic       link_clk_oe;
    logic [1:0] stage_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lps_watchdog #(.T1_CYC(T1), .T2_CYC(T2)) i_lps_watchdog (
        .clk          (clk),
        .rst          (rst),
        .lps_in       (lps_in),
        .direct_mode  (direct_mode),
        .core_data_o  (core_data_o),
        .core_data_oe (core_data_oe),
        .core_ctl_o   (core_ctl_o),
        .core_ctl_oe  (core_ctl_oe),
        .link_data_o  (link_data_o),
        .link_data_oe (link_data_oe),
        .link_ctl_o   (link_ctl_o),
        .link_ctl_oe  (link_ctl_oe),
        .link_rst     (link_rst),
        .link_clk_en  (link_clk_en),
        .link_clk_oe  (link_clk_oe),
        .stage_code   (stage_code)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected outputs derived from the stage and coupling mode.
    task automatic chk_all(input string tag, input logic dm, input logic [1:0] st);
        logic  e_rst;
        logic  e_cen;
        string btag;
        e_rst = (st != 2'd0);
        e_cen = (st != 2'd2);
        btag  = e_rst ? (dm ? "R7 direct park" : "R8 isolated park") : "R10 pass-through";
        chk({tag, " stage"}, int'(stage_code), int'(st));
        chk({tag, " link_rst"}, int'(link_rst), int'(e_rst));
        chk({tag, " clk_en"}, int'(link_clk_en), int'(e_cen));
        chk("R9 clock pin enable", int'(link_clk_oe), int'(dm | e_cen));
        chk("R11 code range", int'(stage_code == 2'd3), 0);
        chk({btag, " data_o"}, int'(link_data_o), e_rst ? 0 : int'(core_data_o));
        chk({btag, " data_oe"}, int'(link_data_oe), e_rst ? int'(dm) : int'(core_data_oe));
        chk({btag, " ctl_o"}, int'(link_ctl_o), e_rst ? 0 : int'(core_ctl_o));
        chk({btag, " ctl_oe"}, int'(link_ctl_oe), e_rst ? int'(dm) : int'(core_ctl_oe));
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_high();
        @(negedge clk);
        lps_in = 1'b1;
        edges(6);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        rst          = 1'b1;
        lps_in       = 1'b0;
        direct_mode  = 1'b1;
        core_data_o  = 8'hA5;
        core_data_oe = 1'b1;
        core_ctl_o   = 2'b11;
        core_ctl_oe  = 1'b1;
        edges(5);
        chk_all("R1 in reset", 1'b1, 2'd2);

        // R1: stays clock-stopped after reset until status seen high.
        rst = 1'b0;
        edges(20);
        chk_all("R1 after release, low", 1'b1, 2'd2);

        // R6: recovery out of the reset state.
        lps_in = 1'b1;
        edges(2);
        chk_all("R6 two edges after rise", 1'b1, 2'd2);
        edges(1);
        chk_all("R6 clock back, reset held", 1'b1, 2'd1);
        edges(1);
        chk_all("R6 released", 1'b1, 2'd0);

        // Table walk: R2, R3, R4 thresholds in both coupling modes.
        for (int i = 0; i < NV; i++) begin
            direct_mode = VECS[i].dm;
            settle_high();
            chk_all("R10 settled normal", VECS[i].dm, 2'd0);
            lps_in = 1'b0;
            edges(VECS[i].n);
            chk_all(VECS[i].st == 2'd2 ? "R3 clock stop" :
                    VECS[i].st == 2'd1 ? "R2 interface reset" : "R2 before threshold",
                    VECS[i].dm, VECS[i].st);
        end

        // R5: a one-cycle high pulse restarts the count.
        direct_mode = 1'b1;
        settle_high();
        lps_in = 1'b0;
        edges(T1);
        chk_all("R5 near threshold", 1'b1, 2'd0);
        lps_in = 1'b1;
        @(negedge clk);
        lps_in = 1'b0;
        edges(T1 + 1);
        chk_all("R5 count restarted", 1'b1, 2'd0);
        edges(1);
        chk_all("R5 threshold after restart", 1'b1, 2'd1);

        // R6: recovery from interface reset, isolated mode.
        direct_mode = 1'b0;
        lps_in = 1'b1;
        edges(2);
        chk_all("R6 from stage1 pending", 1'b0, 2'd1);
        edges(1);
        chk_all("R6 from stage1 recovery", 1'b0, 2'd1);
        edges(1);
        chk_all("R6 from stage1 released", 1'b0, 2'd0);

        // R4 and R6: long low in isolated mode, then recovery.
        lps_in = 1'b0;
        edges(3000);
        chk_all("R4 saturated", 1'b0, 2'd2);
        lps_in = 1'b1;
        edges(2);
        chk_all("R6 isolated still stopped", 1'b0, 2'd2);
        edges(1);
        chk_all("R6 isolated clock back", 1'b0, 2'd1);
        edges(1);
        chk_all("R6 isolated released", 1'b0, 2'd0);

        // R10: pass-through with different core values.
        core_data_o  = 8'h3C;
        core_data_oe = 1'b0;
        core_ctl_o   = 2'b01;
        core_ctl_oe  = 1'b0;
        edges(1);
        chk_all("R10 new core values", 1'b0, 2'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule